// File: doc/BRIEF.md
# Byte-Wide Arithmetic/Logic Unit with Eight-Bit Condition Register

This block is a clocked 8-bit arithmetic and logic unit. It holds its own 8-bit condition-flag register and a registered result. Each strobed cycle it takes a 4-bit operation code, an accumulator byte and an operand byte. It computes the result and rewrites the flag byte. The carry bit already held in the register feeds the carry-using operations. Any flag that an operation leaves alone keeps its stored value.

Fourteen operations are provided:
- arithmetic: add, add-with-carry, subtract, subtract-with-borrow, compare, increment, decrement and negate;
- bitwise: AND, OR and XOR;
- accumulator and carry control: complement-accumulator, set-carry and complement-carry.

The flag byte has a fixed layout. Two of its bits carry no condition at all and simply echo data bits 5 and 3. The source of those two echoes depends on the operation: the result for most operations, the operand for compare, and the accumulator for the carry-control group.

Top module: `alu8_flagcore`

## Requirements
- R1: A high `rst` at a rising edge clears `result_o` and `flags_o` to 0x00, even when `valid_i` is high in the same cycle.
- R2: While `valid_i` is low, `result_o` and `flags_o` keep their values whatever the other inputs do. While `valid_i` is high, both update at the rising edge and are visible after that edge.
- R3: Flag bits are: bit 7 sign, bit 6 zero, bit 5 echo of data bit 5, bit 4 half carry, bit 3 echo of data bit 3, bit 2 parity/overflow, bit 1 subtract, bit 0 carry.
  - Add (op 0) and add-with-carry (op 1, adds the stored carry) give result = acc + opnd (+C).
  - Sign is result bit 7. Zero is set when the result is 0x00. Bits 5 and 3 echo the result.
  - Half carry is the carry from bit 3 into bit 4. Overflow is two's-complement overflow. Subtract is 0. Carry is the carry out of bit 7.
- R4: Subtract (op 2) and subtract-with-borrow (op 3, also subtracts the stored carry) give result = acc - opnd (-C).
  - Sign, zero and the bit 5/3 echoes follow the result. Subtract is 1.
  - Half carry is the borrow into bit 4, carry is the borrow out of bit 7, and parity/overflow is two's-complement overflow.
- R5: Compare (op 4) sets sign, zero, half carry, overflow, subtract and carry exactly as subtract would. Bits 5 and 3 are taken from the operand. `result_o` takes the accumulator value unchanged.
- R6: Increment (op 5) and decrement (op 6) act on the accumulator and never change carry.
  - Increment clears subtract. It sets half carry when the low nibble was 0xF, and sets overflow only for 0x7F.
  - Decrement sets subtract. It sets half carry when the low nibble was 0x0, and sets overflow only for 0x80.
- R7: AND (op 7), OR (op 8) and XOR (op 9) combine the accumulator with the operand.
  - Half carry is 1 for AND and 0 for OR and XOR. Subtract and carry are cleared.
  - Parity/overflow is 1 when the result has an even number of set bits. Sign, zero and bits 5/3 follow the result.
- R8: Negate (op 10) gives 0 - acc with subtract-style flags: subtract 1, carry 1 unless acc is 0x00, overflow only for 0x80. The operand has no effect.
- R9: Complement-accumulator (op 11) gives the bitwise inverse of acc and sets half carry and subtract. Bits 5 and 3 come from the input accumulator. Sign, zero, parity/overflow and carry are kept. `result_o` is ~acc.
- R10: Set-carry (op 12) sets carry and clears half carry and subtract. Bits 5 and 3 come from the accumulator. Sign, zero and parity/overflow are kept. `result_o` takes the accumulator.
- R11: Complement-carry (op 13) inverts carry, loads half carry with the old carry and clears subtract. Bits 5 and 3 come from the accumulator. Sign, zero and parity/overflow are kept. `result_o` takes the accumulator.
- R12: The unassigned codes 14 and 15 change neither `result_o` nor `flags_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe; result and flags load when high |
| op_i | input | 4 | Operation code (0..13 defined, 14/15 no-op) |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand |
| result_o | output | 8 | Registered result |
| flags_o | output | 8 | Registered condition-flag byte |

## Verification
The flags that are hardest to bring about from the ports are the ones an operation must preserve. Complement-accumulator, set-carry and complement-carry keep sign, zero and parity/overflow, and increment/decrement keep carry. With the register at zero, a correct design and one that wrongly clears those bits give the same answer, so the bench would learn nothing. Before every table vector the bench therefore runs an OR of 0x00 with 0x00, which sets zero and parity, and optionally a set-carry. These leave a known non-zero flag byte and a chosen carry in place, so each kept bit is visibly kept and the carry-in of the carry-using operations is controlled.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADC  = 4'd1,
      OP_SUB  = 4'd2,
      OP_SBC  = 4'd3,
      OP_CMP  = 4'd4,
      OP_INC  = 4'd5,
      OP_DEC  = 4'd6,
      OP_AND  = 4'd7,
      OP_OR   = 4'd8,
      OP_XOR  = 4'd9,
      OP_NEG  = 4'd10,
      OP_CPL  = 4'd11,
      OP_SCF  = 4'd12,
      OP_CCF  = 4'd13,
      OP_RSVA = 4'd14,
      OP_RSVB = 4'd15
   } alu_op_e;

   localparam int FL_SIGN = 7;
   localparam int FL_ZERO = 6;
   localparam int FL_X5   = 5;
   localparam int FL_HALF = 4;
   localparam int FL_X3   = 3;
   localparam int FL_PV   = 2;
   localparam int FL_SUB  = 1;
   localparam int FL_CY   = 0;

   localparam int LOGIC_SEL_W = 2;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int W  = 8,
   parameter int HB = 4
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         half_o,
   output logic         carry_o,
   output logic         ovf_o
);
   localparam int MW = W - 1 - HB;

   if (HB < 1 || MW < 1) begin : g_bad_split
      $error("alu8_addsub: half-carry position must leave a middle segment");
   end

   logic [W-1:0]  bx;
   logic          c0;
   logic [HB:0]   lo_seg;
   logic [MW:0]   mid_seg;
   logic [1:0]    top_seg;

   assign bx = b_i ^ {W{sub_i}};
   assign c0 = cin_i ^ sub_i;

   assign lo_seg  = {1'b0, a_i[HB-1:0]} + {1'b0, bx[HB-1:0]} + {{HB{1'b0}}, c0};
   assign mid_seg = {1'b0, a_i[W-2:HB]} + {1'b0, bx[W-2:HB]} + {{MW{1'b0}}, lo_seg[HB]};
   assign top_seg = {1'b0, a_i[W-1]} + {1'b0, bx[W-1]} + {1'b0, mid_seg[MW]};

   assign sum_o   = {top_seg[0], mid_seg[MW-1:0], lo_seg[HB-1:0]};
   assign half_o  = lo_seg[HB] ^ sub_i;
   assign carry_o = top_seg[1] ^ sub_i;
   assign ovf_o   = mid_seg[MW] ^ top_seg[1];

   logic [W:0] whole_ref;
   assign whole_ref = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, c0};

   always_comb begin
      // segmented chain must equal one wide addition (R3, R4)
      p_seg_sum_r3: assert ({top_seg[1], sum_o} == whole_ref)
         else $error("segmented sum mismatch");
   end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int W           = 8,
   parameter bit FAST_PARITY = 1'b1
) (
   input  logic [W-1:0]             a_i,
   input  logic [W-1:0]             b_i,
   input  logic [LOGIC_SEL_W-1:0]   sel_i,
   output logic [W-1:0]             res_o,
   output logic                     even_o
);
   if (W < 2) begin : g_bad_width
      $error("alu8_logic: width must be at least 2");
   end

   always_comb begin
      case (sel_i)
         2'd0:    res_o = a_i & b_i;
         2'd1:    res_o = a_i | b_i;
         2'd2:    res_o = a_i ^ b_i;
         default: res_o = '0;
      endcase
   end

   if (FAST_PARITY) begin : g_par_reduce
      assign even_o = ~(^res_o);
   end else begin : g_par_chain
      logic [W:0] chain;
      assign chain[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_link
         assign chain[i+1] = chain[i] ^ res_o[i];
      end
      assign even_o = ~chain[W];
   end

   always_comb begin
      // parity output means an even count of ones (R7)
      p_even_parity_r7: assert (even_o == (($countones(res_o) % 2) == 0))
         else $error("parity mismatch");
   end

endmodule

// File: rtl/alu8_flagcore.sv
module alu8_flagcore
   import alu8_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int HALF_POS    = 4,
   parameter bit FAST_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   output logic [DATA_W-1:0] result_o,
   output logic [7:0]        flags_o
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W != 8) begin : g_bad_data_w
      $error("alu8_flagcore: flag layout needs an 8-bit datapath");
   end
   if (HALF_POS != DATA_W / 2) begin : g_bad_half
      $error("alu8_flagcore: half carry must sit at the nibble boundary");
   end

   alu_op_e op;
   assign op = alu_op_e'(op_i);

   logic [DATA_W-1:0] res_q, res_d;
   logic [7:0]        flg_q, flg_d;
   logic              c_old;
   assign c_old = flg_q[FL_CY];

   // adder operand steering
   logic [DATA_W-1:0] as_a, as_b, as_sum;
   logic              as_sub, as_cin, as_half, as_cy, as_ovf;

   always_comb begin
      as_a   = acc_i;
      as_b   = opnd_i;
      as_sub = 1'b0;
      as_cin = 1'b0;
      case (op)
         OP_ADC: as_cin = c_old;
         OP_SUB, OP_CMP: as_sub = 1'b1;
         OP_SBC: begin
            as_sub = 1'b1;
            as_cin = c_old;
         end
         OP_INC: begin
            as_b   = '0;
            as_cin = 1'b1;
         end
         OP_DEC: begin
            as_b   = {{(DATA_W-1){1'b0}}, 1'b1};
            as_sub = 1'b1;
         end
         OP_NEG: begin
            as_a   = '0;
            as_b   = acc_i;
            as_sub = 1'b1;
         end
         default: ;
      endcase
   end

   alu8_addsub #(.W(DATA_W), .HB(HALF_POS)) u_addsub (
      .a_i     (as_a),
      .b_i     (as_b),
      .sub_i   (as_sub),
      .cin_i   (as_cin),
      .sum_o   (as_sum),
      .half_o  (as_half),
      .carry_o (as_cy),
      .ovf_o   (as_ovf)
   );

   logic [LOGIC_SEL_W-1:0] lg_sel;
   logic [DATA_W-1:0]      lg_res;
   logic                   lg_even;

   always_comb begin
      case (op)
         OP_OR:   lg_sel = 2'd1;
         OP_XOR:  lg_sel = 2'd2;
         default: lg_sel = 2'd0;
      endcase
   end

   alu8_logic #(.W(DATA_W), .FAST_PARITY(FAST_PARITY)) u_logic (
      .a_i    (acc_i),
      .b_i    (opnd_i),
      .sel_i  (lg_sel),
      .res_o  (lg_res),
      .even_o (lg_even)
   );

   function automatic logic [7:0] pack_flags(
      input logic s, input logic z, input logic x5, input logic h,
      input logic x3, input logic pv, input logic n, input logic c);
      logic [7:0] f;
      f[FL_SIGN] = s;
      f[FL_ZERO] = z;
      f[FL_X5]   = x5;
      f[FL_HALF] = h;
      f[FL_X3]   = x3;
      f[FL_PV]   = pv;
      f[FL_SUB]  = n;
      f[FL_CY]   = c;
      return f;
   endfunction

   logic sum_zero, lg_zero;
   assign sum_zero = (as_sum == '0);
   assign lg_zero  = (lg_res == '0);

   always_comb begin
      res_d = res_q;
      flg_d = flg_q;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
            res_d = as_sum;
            flg_d = pack_flags(as_sum[MSB], sum_zero, as_sum[5], as_half,
                               as_sum[3], as_ovf, as_sub, as_cy);
         end
         OP_CMP: begin
            res_d = acc_i;
            flg_d = pack_flags(as_sum[MSB], sum_zero, opnd_i[5], as_half,
                               opnd_i[3], as_ovf, 1'b1, as_cy);
         end
         OP_INC, OP_DEC: begin
            res_d = as_sum;
            flg_d = pack_flags(as_sum[MSB], sum_zero, as_sum[5], as_half,
                               as_sum[3], as_ovf, as_sub, c_old);
         end
         OP_AND, OP_OR, OP_XOR: begin
            res_d = lg_res;
            flg_d = pack_flags(lg_res[MSB], lg_zero, lg_res[5], (op == OP_AND),
                               lg_res[3], lg_even, 1'b0, 1'b0);
         end
         OP_CPL: begin
            res_d         = ~acc_i;
            flg_d[FL_X5]  = acc_i[5];
            flg_d[FL_X3]  = acc_i[3];
            flg_d[FL_HALF] = 1'b1;
            flg_d[FL_SUB] = 1'b1;
         end
         OP_SCF: begin
            res_d          = acc_i;
            flg_d[FL_X5]   = acc_i[5];
            flg_d[FL_X3]   = acc_i[3];
            flg_d[FL_HALF] = 1'b0;
            flg_d[FL_SUB]  = 1'b0;
            flg_d[FL_CY]   = 1'b1;
         end
         OP_CCF: begin
            res_d          = acc_i;
            flg_d[FL_X5]   = acc_i[5];
            flg_d[FL_X3]   = acc_i[3];
            flg_d[FL_HALF] = c_old;
            flg_d[FL_SUB]  = 1'b0;
            flg_d[FL_CY]   = ~c_old;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q <= '0;
         flg_q <= '0;
      end else if (valid_i) begin
         res_q <= res_d;
         flg_q <= flg_d;
      end
   end

   assign result_o = res_q;
   assign flags_o  = flg_q;

   // ---------------- assertions ----------------
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (flags_o == 8'h00 && result_o == '0))
      else $error("reset did not clear state");

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> ($stable(flags_o) && $stable(result_o)))
      else $error("state moved without strobe");

   p_cmp_keeps_acc_r5: assert property (@(posedge clk) disable iff (rst)
      (valid_i && op_i == OP_CMP) |=> (result_o == $past(acc_i)))
      else $error("compare altered result");

   p_incdec_carry_r6: assert property (@(posedge clk) disable iff (rst)
      (valid_i && (op_i == OP_INC || op_i == OP_DEC))
         |=> (flags_o[FL_CY] == $past(flags_o[FL_CY])))
      else $error("inc/dec touched carry");

   p_logic_clears_r7: assert property (@(posedge clk) disable iff (rst)
      (valid_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR))
         |=> (flags_o[FL_SUB] == 1'b0 && flags_o[FL_CY] == 1'b0))
      else $error("logic op left N or C set");

   p_cpl_keeps_r9: assert property (@(posedge clk) disable iff (rst)
      (valid_i && op_i == OP_CPL)
         |=> (flags_o[FL_SIGN] == $past(flags_o[FL_SIGN]) &&
              flags_o[FL_ZERO] == $past(flags_o[FL_ZERO]) &&
              flags_o[FL_PV]   == $past(flags_o[FL_PV]) &&
              flags_o[FL_CY]   == $past(flags_o[FL_CY])))
      else $error("complement changed kept flags");

   p_scf_sets_r10: assert property (@(posedge clk) disable iff (rst)
      (valid_i && op_i == OP_SCF)
         |=> (flags_o[FL_CY] && !flags_o[FL_HALF] && !flags_o[FL_SUB]))
      else $error("set-carry flags wrong");

   p_ccf_swap_r11: assert property (@(posedge clk) disable iff (rst)
      (valid_i && op_i == OP_CCF)
         |=> (flags_o[FL_CY] != $past(flags_o[FL_CY]) &&
              flags_o[FL_HALF] == $past(flags_o[FL_CY])))
      else $error("complement-carry flags wrong");

   p_reserved_noop_r12: assert property (@(posedge clk) disable iff (rst)
      (valid_i && (op_i == OP_RSVA || op_i == OP_RSVB))
         |=> ($stable(flags_o) && $stable(result_o)))
      else $error("reserved code changed state");

endmodule

// File: tb/alu8_flagcore_tb.sv
module alu8_flagcore_tb_top;

   logic       clk = 1'b0;
   logic       rst;
   logic       valid_i;
   logic [3:0] op_i;
   logic [7:0] acc_i;
   logic [7:0] opnd_i;
   logic [7:0] result_o;
   logic [7:0] flags_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   alu8_flagcore dut_i (
      .clk      (clk),
      .rst      (rst),
      .valid_i  (valid_i),
      .op_i     (op_i),
      .acc_i    (acc_i),
      .opnd_i   (opnd_i),
      .result_o (result_o),
      .flags_o  (flags_o)
   );

   // {op, acc, opnd, carry_in, exp_result, exp_flags}
   localparam int NV = 24;
   localparam logic [36:0] VEC [0:NV-1] = '{
      {4'd0,  8'h0F, 8'h01, 1'b0, 8'h10, 8'h10},
      {4'd0,  8'h7F, 8'h01, 1'b0, 8'h80, 8'h94},
      {4'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 8'h51},
      {4'd1,  8'h28, 8'h10, 1'b1, 8'h39, 8'h28},
      {4'd2,  8'h10, 8'h01, 1'b0, 8'h0F, 8'h1A},
      {4'd2,  8'h80, 8'h01, 1'b0, 8'h7F, 8'h3E},
      {4'd3,  8'h00, 8'h00, 1'b1, 8'hFF, 8'hBB},
      {4'd4,  8'h40, 8'h28, 1'b0, 8'h40, 8'h3A},
      {4'd4,  8'h5A, 8'h5A, 1'b0, 8'h5A, 8'h4A},
      {4'd5,  8'h7F, 8'h00, 1'b1, 8'h80, 8'h95},
      {4'd6,  8'h80, 8'h00, 1'b1, 8'h7F, 8'h3F},
      {4'd6,  8'h01, 8'h00, 1'b0, 8'h00, 8'h42},
      {4'd5,  8'hFF, 8'h00, 1'b0, 8'h00, 8'h50},
      {4'd7,  8'hF0, 8'h3C, 1'b1, 8'h30, 8'h34},
      {4'd8,  8'h80, 8'h01, 1'b1, 8'h81, 8'h84},
      {4'd9,  8'hFF, 8'hF8, 1'b1, 8'h07, 8'h00},
      {4'd10, 8'h01, 8'h00, 1'b0, 8'hFF, 8'hBB},
      {4'd10, 8'h80, 8'hAA, 1'b0, 8'h80, 8'h87},
      {4'd10, 8'h00, 8'h55, 1'b0, 8'h00, 8'h42},
      {4'd11, 8'h28, 8'h00, 1'b0, 8'hD7, 8'h7E},
      {4'd12, 8'h08, 8'h00, 1'b0, 8'h08, 8'h4D},
      {4'd13, 8'h20, 8'h00, 1'b1, 8'h20, 8'h74},
      {4'd13, 8'h00, 8'h00, 1'b0, 8'h00, 8'h45},
      {4'd14, 8'h12, 8'h34, 1'b1, 8'h00, 8'h45}
   };

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'd0, 4'd1:       return "R3";
         4'd2, 4'd3:       return "R4";
         4'd4:             return "R5";
         4'd5, 4'd6:       return "R6";
         4'd7, 4'd8, 4'd9: return "R7";
         4'd10:            return "R8";
         4'd11:            return "R9";
         4'd12:            return "R10";
         4'd13:            return "R11";
         default:          return "R12";
      endcase
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
      end
   endtask

   // drive at negedge; outputs load at the next posedge and are read at the following negedge
   task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
      @(negedge clk);
      op_i    = op;
      acc_i   = a;
      opnd_i  = b;
      valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst     = 1'b1;
      valid_i = 1'b0;
      op_i    = 4'd0;
      acc_i   = 8'h00;
      opnd_i  = 8'h00;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      check("R1", "reset result", result_o, 8'h00);
      check("R1", "reset flags", flags_o, 8'h00);

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [3:0] v_op;
         logic [7:0] v_acc, v_opnd, v_res, v_flg;
         logic       v_cin;
         v_op   = VEC[i][36:33];
         v_acc  = VEC[i][32:25];
         v_opnd = VEC[i][24:17];
         v_cin  = VEC[i][16];
         v_res  = VEC[i][15:8];
         v_flg  = VEC[i][7:0];
         apply(4'd8, 8'h00, 8'h00);        // flags become 0x44
         if (v_cin) apply(4'd12, 8'h00, 8'h00);  // flags become 0x45
         apply(v_op, v_acc, v_opnd);
         check(tag_of(v_op), "result", result_o, v_res);
         check(tag_of(v_op), "flags", flags_o, v_flg);
      end

      // R2: strobe low holds state despite changing inputs
      apply(4'd0, 8'hFF, 8'h01);
      check("R2", "loaded flags", flags_o, 8'h51);
      @(negedge clk);
      op_i   = 4'd0;
      acc_i  = 8'h7F;
      opnd_i = 8'h01;
      repeat (3) @(negedge clk);
      check("R2", "held result", result_o, 8'h00);
      check("R2", "held flags", flags_o, 8'h51);

      // R1: reset wins over a strobe in the same cycle
      apply(4'd0, 8'h7F, 8'h01);
      check("R3", "pre-reset result", result_o, 8'h80);
      @(negedge clk);
      rst     = 1'b1;
      valid_i = 1'b1;
      op_i    = 4'd0;
      acc_i   = 8'h01;
      opnd_i  = 8'h01;
      @(negedge clk);
      rst     = 1'b0;
      valid_i = 1'b0;
      check("R1", "reset with strobe result", result_o, 8'h00);
      check("R1", "reset with strobe flags", flags_o, 8'h00);

      // R12: code 15 leaves a non-zero state alone
      apply(4'd11, 8'h28, 8'h00);       // from 0x00: flags 0x3A, result 0xD7
      apply(4'd15, 8'hFF, 8'hFF);
      check("R12", "reserved result", result_o, 8'hD7);
      check("R12", "reserved flags", flags_o, 8'h3A);

      finish_run();
   end

endmodule